// File: doc/BRIEF.md
# Chip Reset Sequencer

This block produces the hard and soft reset pins of a processor-style device, together with an internal power-on reset for core logic and a one-cycle strobe that tells the configuration logic to capture its settings. Reset can come from a power-on input, from the two reset pins being pulled low by something outside, or from internal request lines. Each reset pin is open-drain: the block only asks the pad to pull the pin low, and it reads the real pin level back through a separate sense input. A pull-up outside the block raises the pin.

A hard reset pulls both pins for one fixed stretch. A soft reset pulls only the soft pin, for a shorter stretch. After power-on, both pins stay pulled until the PLL reports lock. Each pin then has its own extra hold. Once the block lets go of the pins, it waits until it senses both pins high. It then lets a short settle window pass before it reacts to an external pin again. A two-bit status output shows which flow is running.

Top module: `rst_seq_top`

## Requirements
- R1: An internal hard request, or an external hard-pin assertion seen while idle, raises `hrst_pull_en` and `srst_pull_en` together for exactly 1024 cycles, and both drop in the same cycle. `cfg_sample` is high for exactly one cycle, the first cycle of that flow.
- R2: An internal soft request raises only `srst_pull_en`, for exactly 512 cycles. `hrst_pull_en` stays low and `cfg_sample` does not pulse.
- R3: A hard request that arrives during a soft flow starts a full 1024-cycle hard flow at once, and `srst_pull_en` stays high the whole time. A soft request during a hard flow has no effect: no extra pulse follows, and status returns to idle.
- R4: After the pull enables drop, status keeps showing the last flow until both sense inputs are seen high.
- R5: The settle window is 16 cycles. Status reads idle 19 cycles after the last pin rises (2 for the synchronizer, 1 for detection, 16 for settle). An external pin pulse inside that window is ignored. Once idle, an external pin assertion starts its flow 3 cycles after the pin falls.
- R6: A power-on pulse (`por_pin_n` low) counts only if it lasts at least 16 cycles. A 15-cycle pulse changes nothing.
- R7: `core_por_n` stays low while power-on is valid. It rises exactly 1027 cycles after `por_pin_n` rises: 2 for the synchronizer, 1 for filter release, then 1024 counted.
- R8: During power-on, both pull enables stay high until `pll_lock` is seen. Counting from the cycle `pll_lock` is raised, `hrst_pull_en` drops after 513 cycles and `srst_pull_en` after 516 (hold times of 512 and 515), and `cfg_sample` pulses in the first cycle.
- R9: A valid power-on aborts any flow in progress and restarts the power-on sequence.
- R10: `flow` encoding: 0 = idle, 1 = power-on, 2 = hard, 3 = soft. In idle, both pull enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock; every count is in its cycles |
| por_pin_n | input | 1 | Asynchronous power-on reset, active low |
| hrst_sense_n | input | 1 | Sensed level of the hard-reset pin, low = asserted |
| srst_sense_n | input | 1 | Sensed level of the soft-reset pin, low = asserted |
| pll_lock | input | 1 | PLL lock indication, synchronous |
| int_hard_req | input | 1 | Internal hard-reset request, synchronous |
| int_soft_req | input | 1 | Internal soft-reset request, synchronous |
| hrst_pull_en | output | 1 | High = pad drives the hard-reset pin low |
| srst_pull_en | output | 1 | High = pad drives the soft-reset pin low |
| core_por_n | output | 1 | Power-on reset to core logic, active low |
| cfg_sample | output | 1 | One-cycle strobe to capture configuration |
| flow | output | 2 | Current flow: 0 idle, 1 power-on, 2 hard, 3 soft |

## Verification
A wrong stretch counter shows up at the pins as a pulse that is too long or too short. It becomes visible in the cycle the pull enable drops, up to 1024 cycles after the error. A sequencer stuck in the wrong state is visible sooner. Within one cycle, `flow` shows a wrong code, `hrst_pull_en` rises without `srst_pull_en`, or `cfg_sample` pulses during a soft flow. A fault in the negation or settle logic shows up as a wrong idle time after the pins rise, or as a flow that starts during settle. A fault in the power-on filter shows up as `core_por_n` falling after a short pulse.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

  typedef enum logic [2:0] {
    ST_POR    = 3'd0,
    ST_PLLX   = 3'd1,
    ST_HARD   = 3'd2,
    ST_SOFT   = 3'd3,
    ST_WNEG   = 3'd4,
    ST_SETTLE = 3'd5,
    ST_IDLE   = 3'd6
  } seq_st_e;

  typedef enum logic [1:0] {
    FL_IDLE = 2'd0,
    FL_POR  = 2'd1,
    FL_HARD = 2'd2,
    FL_SOFT = 2'd3
  } flow_e;

  function automatic int unsigned f_max(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // true in the last cycle of a stretch of len cycles counted from 0
  function automatic logic f_at_end(int unsigned cnt, int unsigned len);
    return (cnt + 1) == len;
  endfunction

endpackage

// File: rtl/rst_sync.sv
module rst_sync #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    meta_q <= d;
    q      <= meta_q;
  end
endmodule

// File: rtl/rst_por_filter.sv
module rst_por_filter #(
  parameter int unsigned POR_MIN  = 16,
  parameter int unsigned CORE_EXT = 1024
) (
  input  logic clk,
  input  logic por_s,
  output logic por_valid,
  output logic core_por_n
);
  localparam int unsigned FW = $clog2(POR_MIN + 1);
  localparam int unsigned EW = $clog2(CORE_EXT + 1);

  logic [FW-1:0] low_cnt_q;
  logic [EW-1:0] ext_cnt_q;

  // consecutive low samples, saturating at the qualification length
  always_ff @(posedge clk) begin
    if (por_s)                          low_cnt_q <= '0;
    else if (low_cnt_q != FW'(POR_MIN)) low_cnt_q <= low_cnt_q + 1'b1;
  end

  assign por_valid = (low_cnt_q == FW'(POR_MIN));

  // core reset extension counted from the release of a valid pulse
  always_ff @(posedge clk) begin
    if (por_valid)                        ext_cnt_q <= '0;
    else if (ext_cnt_q != EW'(CORE_EXT))  ext_cnt_q <= ext_cnt_q + 1'b1;
  end

  assign core_por_n = (ext_cnt_q == EW'(CORE_EXT));
endmodule

// File: rtl/rst_seq_fsm.sv
module rst_seq_fsm
  import rst_seq_pkg::*;
#(
  parameter int unsigned HARD_CYC   = 1024,
  parameter int unsigned SOFT_CYC   = 512,
  parameter int unsigned SETTLE_CYC = 16,
  parameter int unsigned LOCK_HX    = 512,
  parameter int unsigned LOCK_SX    = 515
) (
  input  logic       clk,
  input  logic       por_valid,
  input  logic       pll_lock,
  input  logic       hrst_s,
  input  logic       srst_s,
  input  logic       hard_req,
  input  logic       soft_req,
  output logic       hrst_oe,
  output logic       srst_oe,
  output logic       cfg_sample,
  output logic       ev_hard_start,
  output logic [1:0] flow
);
  localparam int unsigned TOP_CNT =
    f_max(f_max(HARD_CYC, SOFT_CYC), f_max(f_max(LOCK_HX, LOCK_SX), SETTLE_CYC));
  localparam int unsigned CW = $clog2(TOP_CNT + 1);

  seq_st_e st_q, st_d;
  flow_e   last_q, last_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic go_hard, go_soft;
  logic hard_in, soft_in;

  assign hard_in = hard_req | ~hrst_s;
  assign soft_in = soft_req | ~srst_s;

  always_comb begin
    st_d    = st_q;
    last_d  = last_q;
    cnt_d   = cnt_q + 1'b1;
    go_hard = 1'b0;
    go_soft = 1'b0;
    case (st_q)
      ST_POR: begin
        cnt_d = '0;
        if (pll_lock) st_d = ST_PLLX;
      end
      ST_PLLX:
        if (f_at_end(32'(cnt_q), LOCK_SX)) st_d = ST_WNEG;
      ST_HARD:
        if (f_at_end(32'(cnt_q), HARD_CYC)) st_d = ST_WNEG;
      ST_SOFT:
        if (hard_in) go_hard = 1'b1;
        else if (f_at_end(32'(cnt_q), SOFT_CYC)) st_d = ST_WNEG;
      ST_WNEG: begin
        cnt_d = '0;
        if (hard_req)            go_hard = 1'b1;
        else if (soft_req)       go_soft = 1'b1;
        else if (hrst_s && srst_s) st_d = ST_SETTLE;
      end
      ST_SETTLE:
        if (hard_req)      go_hard = 1'b1;
        else if (soft_req) go_soft = 1'b1;
        else if (f_at_end(32'(cnt_q), SETTLE_CYC)) st_d = ST_IDLE;
      ST_IDLE: begin
        cnt_d = '0;
        if (hard_in)      go_hard = 1'b1;
        else if (soft_in) go_soft = 1'b1;
      end
      default: st_d = ST_POR;
    endcase
    if (go_hard) begin
      st_d = ST_HARD; cnt_d = '0; last_d = FL_HARD;
    end else if (go_soft) begin
      st_d = ST_SOFT; cnt_d = '0; last_d = FL_SOFT;
    end
    if (por_valid) begin
      st_d = ST_POR; cnt_d = '0; last_d = FL_POR;
    end
  end

  always_ff @(posedge clk) begin
    st_q   <= st_d;
    cnt_q  <= cnt_d;
    last_q <= last_d;
  end

  assign ev_hard_start = go_hard & ~por_valid;

  assign cfg_sample = ((st_q == ST_HARD) || (st_q == ST_PLLX)) && (cnt_q == '0);
  assign hrst_oe = (st_q == ST_POR) || (st_q == ST_HARD) ||
                   ((st_q == ST_PLLX) && (cnt_q < CW'(LOCK_HX)));
  assign srst_oe = (st_q == ST_POR) || (st_q == ST_HARD) || (st_q == ST_SOFT) ||
                   ((st_q == ST_PLLX) && (cnt_q < CW'(LOCK_SX)));

  always_comb begin
    case (st_q)
      ST_POR, ST_PLLX: flow = FL_POR;
      ST_HARD:         flow = FL_HARD;
      ST_SOFT:         flow = FL_SOFT;
      ST_IDLE:         flow = FL_IDLE;
      default:         flow = last_q;
    endcase
  end
endmodule

// File: rtl/rst_seq_top.sv
module rst_seq_top #(
  parameter int unsigned HARD_CYC   = 1024,
  parameter int unsigned SOFT_CYC   = 512,
  parameter int unsigned SETTLE_CYC = 16,
  parameter int unsigned POR_MIN    = 16,
  parameter int unsigned CORE_EXT   = 1024,
  parameter int unsigned LOCK_HX    = 512,
  parameter int unsigned LOCK_SX    = 515
) (
  input  logic       clk,
  input  logic       por_pin_n,
  input  logic       hrst_sense_n,
  input  logic       srst_sense_n,
  input  logic       pll_lock,
  input  logic       int_hard_req,
  input  logic       int_soft_req,
  output logic       hrst_pull_en,
  output logic       srst_pull_en,
  output logic       core_por_n,
  output logic       cfg_sample,
  output logic [1:0] flow
);
  logic [2:0] sync_q;
  logic por_s, hrst_s, srst_s;
  logic por_valid;
  logic ev_hard_start;

  rst_sync #(.W(3)) u_sync (
    .clk (clk),
    .d   ({por_pin_n, hrst_sense_n, srst_sense_n}),
    .q   (sync_q)
  );
  assign por_s  = sync_q[2];
  assign hrst_s = sync_q[1];
  assign srst_s = sync_q[0];

  rst_por_filter #(.POR_MIN(POR_MIN), .CORE_EXT(CORE_EXT)) u_por (
    .clk        (clk),
    .por_s      (por_s),
    .por_valid  (por_valid),
    .core_por_n (core_por_n)
  );

  rst_seq_fsm #(
    .HARD_CYC(HARD_CYC), .SOFT_CYC(SOFT_CYC), .SETTLE_CYC(SETTLE_CYC),
    .LOCK_HX(LOCK_HX), .LOCK_SX(LOCK_SX)
  ) u_fsm (
    .clk           (clk),
    .por_valid     (por_valid),
    .pll_lock      (pll_lock),
    .hrst_s        (hrst_s),
    .srst_s        (srst_s),
    .hard_req      (int_hard_req),
    .soft_req      (int_soft_req),
    .hrst_oe       (hrst_pull_en),
    .srst_oe       (srst_pull_en),
    .cfg_sample    (cfg_sample),
    .ev_hard_start (ev_hard_start),
    .flow          (flow)
  );
endmodule

// File: rtl/rst_seq_chk.sv
module rst_seq_chk #(
  parameter int unsigned HARD_CYC = 1024
) (
  input logic       clk,
  input logic       por_valid,
  input logic       ev_hard_start,
  input logic       hrst_oe,
  input logic       srst_oe,
  input logic       cfg_sample,
  input logic       core_por_n,
  input logic [1:0] flow
);
  logic        armed;
  logic [15:0] hcnt;

  always_ff @(posedge clk) begin
    if (por_valid) armed <= 1'b1;
    if (hrst_oe) hcnt <= hcnt + 16'd1;
    else         hcnt <= 16'd0;
  end

  // R1: the hard pin is never pulled without the soft pin
  a_r1_hard_with_soft: assert property (@(posedge clk) disable iff (!armed || por_valid)
    hrst_oe |-> srst_oe);

  // R1: a hard flow start is followed by one strobe cycle
  a_r1_start_strobe: assert property (@(posedge clk) disable iff (!armed || por_valid)
    ev_hard_start |=> cfg_sample);

  a_r1_strobe_single: assert property (@(posedge clk) disable iff (!armed || por_valid)
    cfg_sample |=> !cfg_sample);

  // R1: length of a hard stretch, checked by counter
  a_r1_hard_len: assert property (@(posedge clk) disable iff (!armed || por_valid)
    ($past(hrst_oe) && !hrst_oe && ($past(flow) == 2'd2)) |-> (hcnt == 16'(HARD_CYC)));

  // R2: no configuration strobe in a soft flow
  a_r2_soft_no_cfg: assert property (@(posedge clk) disable iff (!armed || por_valid)
    (flow == 2'd3) |-> !cfg_sample);

  // R10: idle means both pins released
  a_r10_idle_released: assert property (@(posedge clk) disable iff (!armed || por_valid)
    (flow == 2'd0) |-> (!hrst_oe && !srst_oe));

  // R7: core reset held after a valid power-on
  a_r7_core_held: assert property (@(posedge clk) disable iff (!armed)
    por_valid |=> !core_por_n);
endmodule

bind rst_seq_top rst_seq_chk #(.HARD_CYC(HARD_CYC)) u_chk (
  .clk           (clk),
  .por_valid     (por_valid),
  .ev_hard_start (ev_hard_start),
  .hrst_oe       (hrst_pull_en),
  .srst_oe       (srst_pull_en),
  .cfg_sample    (cfg_sample),
  .core_por_n    (core_por_n),
  .flow          (flow)
);

// File: tb/rst_seq_top_tb_top.sv
module rst_seq_top_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic por_pin_n, pll_lock, int_hard_req, int_soft_req;
  logic ext_h, ext_s;
  logic hrst_pull_en, srst_pull_en, core_por_n, cfg_sample;
  logic [1:0] flow;
  wire hrst_sense_n = ~(hrst_pull_en | ext_h);
  wire srst_sense_n = ~(srst_pull_en | ext_s);

  rst_seq_top dut_i (
    .clk(clk), .por_pin_n(por_pin_n), .hrst_sense_n(hrst_sense_n),
    .srst_sense_n(srst_sense_n), .pll_lock(pll_lock),
    .int_hard_req(int_hard_req), .int_soft_req(int_soft_req),
    .hrst_pull_en(hrst_pull_en), .srst_pull_en(srst_pull_en),
    .core_por_n(core_por_n), .cfg_sample(cfg_sample), .flow(flow)
  );

  int n_cmp = 0;
  int n_bad = 0;

  task automatic chk(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // scoreboard: kind 0 = strobe, 1 = hard pulse length, 2 = soft pulse length
  typedef struct { int kind; int len; string req; } item_t;
  item_t exp_q[$];
  logic mon_on = 1'b0;

  task automatic push(int kind, int len, string req);
    item_t it;
    it.kind = kind; it.len = len; it.req = req;
    exp_q.push_back(it);
  endtask

  task automatic observed(int kind, int len);
    item_t it;
    if (exp_q.size() == 0) begin
      chk("unexpected event kind", kind, -1);
    end else begin
      it = exp_q.pop_front();
      chk({it.req, " kind"}, kind, it.kind);
      chk({it.req, " length"}, len, it.len);
    end
  endtask

  int  hlen = 0, slen = 0;
  logic hprev = 1'b0, sprev = 1'b0;
  always @(negedge clk) begin
    if (mon_on && cfg_sample) observed(0, 0);
    if (hrst_pull_en) hlen++;
    else begin
      if (hprev && mon_on) observed(1, hlen);
      hlen = 0;
    end
    if (srst_pull_en) slen++;
    else begin
      if (sprev && mon_on) observed(2, slen);
      slen = 0;
    end
    hprev = hrst_pull_en;
    sprev = srst_pull_en;
  end

  task automatic wait_idle();
    while (flow != 2'd0) @(negedge clk);
  endtask

  task automatic pulse_req(logic hard);
    if (hard) int_hard_req = 1'b1; else int_soft_req = 1'b1;
    @(negedge clk);
    int_hard_req = 1'b0; int_soft_req = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int k, kh, ks;
    int hseen;
    por_pin_n = 1'b0; pll_lock = 1'b0; int_hard_req = 1'b0; int_soft_req = 1'b0;
    ext_h = 1'b0; ext_s = 1'b0;
    repeat (20) @(negedge clk);
    chk("R10 flow in power-on", flow, 1);
    chk("R8 hard pulled in power-on", hrst_pull_en, 1);
    chk("R8 soft pulled in power-on", srst_pull_en, 1);
    chk("R7 core reset low", core_por_n, 0);

    por_pin_n = 1'b1;
    k = 0;
    while (!core_por_n && k < 5000) begin @(negedge clk); k++; end
    chk("R7 core reset release delay", k, 1027);

    repeat (300) @(negedge clk);
    chk("R8 hard held without lock", hrst_pull_en, 1);
    chk("R8 soft held without lock", srst_pull_en, 1);

    pll_lock = 1'b1;
    k = 0; kh = 0; ks = 0;
    while (ks == 0 && k < 2000) begin
      @(negedge clk); k++;
      if (k == 1) chk("R8 strobe after lock", cfg_sample, 1);
      if (kh == 0 && !hrst_pull_en) kh = k;
      if (ks == 0 && !srst_pull_en) ks = k;
    end
    chk("R8 hard release after lock", kh, 513);
    chk("R8 soft release after lock", ks, 516);
    wait_idle();
    chk("R10 idle pins released", {hrst_pull_en, srst_pull_en}, 0);
    mon_on = 1'b1;

    // R1 internal hard flow, R3 soft request ignored inside it
    push(0, 0, "R1 strobe"); push(1, 1024, "R1 hard"); push(2, 1024, "R1 soft");
    pulse_req(1'b1);
    chk("R10 flow hard", flow, 2);
    repeat (300) @(negedge clk);
    pulse_req(1'b0);
    wait_idle();
    repeat (20) @(negedge clk);
    chk("R3 soft request during hard ignored", flow, 0);
    chk("R3 no soft pulse after hard", srst_pull_en, 0);

    // R2 internal soft flow
    push(2, 512, "R2 soft");
    pulse_req(1'b0);
    chk("R10 flow soft", flow, 3);
    chk("R2 hard pin untouched", hrst_pull_en, 0);
    wait_idle();

    // R3 upgrade of soft to hard
    push(0, 0, "R3 strobe"); push(1, 1024, "R3 hard"); push(2, 1124, "R3 soft");
    pulse_req(1'b0);
    repeat (99) @(negedge clk);
    pulse_req(1'b1);
    chk("R3 flow upgraded", flow, 2);
    wait_idle();

    // R4/R5 external hard hold, negation wait, settle window
    push(0, 0, "R4 strobe"); push(1, 1024, "R4 hard"); push(2, 1024, "R4 soft");
    ext_h = 1'b1;
    repeat (1100) @(negedge clk);
    chk("R4 flow held until negation", flow, 2);
    chk("R4 pull released", {hrst_pull_en, srst_pull_en}, 0);
    ext_h = 1'b0;
    k = 0; hseen = 0;
    while (flow != 2'd0 && k < 200) begin
      @(negedge clk); k++;
      if (k == 4) ext_h = 1'b1;
      if (k == 7) ext_h = 1'b0;
      if (hrst_pull_en) hseen = 1;
    end
    chk("R5 idle after negation", k, 19);
    repeat (30) @(negedge clk);
    if (hrst_pull_en) hseen = 1;
    chk("R5 pulse in settle ignored", hseen, 0);

    // R5 external soft pin after settle
    push(2, 512, "R5 soft");
    ext_s = 1'b1;
    k = 0;
    while (!srst_pull_en && k < 50) begin @(negedge clk); k++; end
    chk("R5 external start latency", k, 3);
    repeat (5) @(negedge clk);
    ext_s = 1'b0;
    wait_idle();

    // R6 short power-on pulse ignored
    por_pin_n = 1'b0;
    repeat (15) @(negedge clk);
    por_pin_n = 1'b1;
    repeat (30) @(negedge clk);
    chk("R6 short pulse flow", flow, 0);
    chk("R6 short pulse core reset", core_por_n, 1);

    // R9 power-on during hard flow, R6 16-cycle pulse accepted
    mon_on = 1'b0;
    pulse_req(1'b1);
    repeat (200) @(negedge clk);
    por_pin_n = 1'b0;
    repeat (16) @(negedge clk);
    por_pin_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R9 flow restarted at power-on", flow, 1);
    chk("R6 16-cycle pulse accepted", core_por_n, 0);
    wait_idle();
    while (!core_por_n) @(negedge clk);
    chk("R9 idle after restart", flow, 0);
    chk("scoreboard drained", exp_q.size(), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule